// File: doc/BRIEF.md
# Supply and Thermal Protection Supervisor

This block watches two digital codes, one for the supply voltage and one for the die temperature, and turns them into protection flags for a power-stage gate driver. A supply-good flag uses a start and a stop threshold with a hysteresis band between them. A thermal-warning flag uses its own pair of thresholds, and it only informs the system. A thermal-shutdown latch trips above a higher temperature limit. It stays set when the die cools and clears only after an undervoltage event.

While the shutdown latch is set, the block drives a pull-down request onto the shared enable line so the system controller can see the trip. The gate sequencer receives a single run permit. The permit is true only when the supply is good, the shutdown latch is clear and the external enable is high. All inputs are captured in a register stage, and every flag is a flop, so the outputs change only on clock edges. Thresholds are parameters in code units.

Top module: `pwr_therm_guard`

## Requirements
- R1: While rst_ni is low, supply_ok_o, therm_warn_o, shdn_o, en_pull_o and run_permit_o are all 0.
- R2: supply_ok_o goes from 0 to 1 on the second rising edge after supply_code_i is presented above V_START (default 430). A code equal to V_START does not set it.
- R3: Once set, supply_ok_o stays 1 while supply_code_i is above V_STOP (default 380), and it clears when the code is at or below V_STOP. Once cleared, it stays 0 for codes between V_STOP and V_START.
- R4: therm_warn_o sets on the second rising edge after temp_code_i is presented above T_WARN_HI (default 115). A code equal to T_WARN_HI does not set it.
- R5: Once set, therm_warn_o holds while temp_code_i is above T_WARN_LO (default 100), and it clears when the code is at or below T_WARN_LO.
- R6: therm_warn_o has no effect on run_permit_o.
- R7: shdn_o sets on the second rising edge after temp_code_i is presented above T_SHDN (default 150) while supply_ok_o is 1. A code equal to T_SHDN does not trip it. en_pull_o equals shdn_o at all times.
- R8: Once set, shdn_o stays 1 when the temperature falls, for as long as supply_ok_o stays 1.
- R9: shdn_o clears on the rising edge after the one that clears supply_ok_o. While supply_ok_o is 0, a temperature above T_SHDN does not set it.
- R10: run_permit_o = supply_ok_o AND NOT shdn_o AND the value ext_en_i had at the previous rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| supply_code_i | input | VW (10) | Supply voltage code |
| temp_code_i | input | TW (8) | Die temperature code |
| ext_en_i | input | 1 | Level of the external enable line |
| supply_ok_o | output | 1 | Supply good, with hysteresis |
| therm_warn_o | output | 1 | Thermal warning, with hysteresis, indication only |
| shdn_o | output | 1 | Latched thermal shutdown |
| en_pull_o | output | 1 | Pull-down request on the shared enable line |
| run_permit_o | output | 1 | Permission for the gate sequencer to switch |

## Verification
Each hysteresis comparator is first driven to its threshold and then one code past it. This separates a strict comparison from an inclusive one at both the set threshold and the clear threshold. The bench also steps codes inside the hysteresis band from both sides, which shows that the flag holds its state rather than following a single threshold. The shutdown sequence checks several things:
- the temperature dropping back, which must not release the latch;
- a supply dip that stays inside the band, which must not release it either;
- a real undervoltage, where the release must come one edge after supply_ok_o falls;
- a high temperature during undervoltage, which must not re-arm the latch.

Toggling the external enable and the warning by themselves isolates each term of the run permit.

// File: rtl/pwr_therm_pkg.sv
package pwr_therm_pkg;

  typedef struct packed {
    logic supply_ok;
    logic warn;
    logic shdn;
  } guard_flags_t;

endpackage

// File: rtl/in_capture.sv
module in_capture #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= d_i;
  end
endmodule

// File: rtl/hyst_cmp.sv
module hyst_cmp #(
  parameter int unsigned W  = 8,
  parameter int unsigned HI = 2,
  parameter int unsigned LO = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] val_i,
  output logic         flag_o
);
  localparam logic [W-1:0] HiC = HI[W-1:0];
  localparam logic [W-1:0] LoC = LO[W-1:0];

  logic above_hi, at_or_below_lo;
  assign above_hi       = val_i > HiC;
  assign at_or_below_lo = val_i <= LoC;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             flag_o <= 1'b0;
    else if (above_hi)       flag_o <= 1'b1;
    else if (at_or_below_lo) flag_o <= 1'b0;
  end

  // R2 / R4: set only from a strictly-above sample
  p_set_above_hi_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_o) |-> ($past(val_i) > HiC));
  // R3 / R5: clear only from an at-or-below sample
  p_clear_at_lo_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flag_o) |-> ($past(val_i) <= LoC));
endmodule

// File: rtl/trip_latch.sv
module trip_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic trip_i,
  output logic latch_o
);
  // disarm (undervoltage) dominates; latch ignores trip_i falling
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     latch_o <= 1'b0;
    else if (!arm_i) latch_o <= 1'b0;
    else if (trip_i) latch_o <= 1'b1;
  end

  p_hold_while_armed_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (latch_o && arm_i) |=> latch_o);
  p_clear_on_uv_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !arm_i |=> !latch_o);
endmodule

// File: rtl/pwr_therm_guard.sv
module pwr_therm_guard
  import pwr_therm_pkg::*;
#(
  parameter int unsigned VW        = 10,
  parameter int unsigned TW        = 8,
  parameter int unsigned V_START   = 430,
  parameter int unsigned V_STOP    = 380,
  parameter int unsigned T_WARN_HI = 115,
  parameter int unsigned T_WARN_LO = 100,
  parameter int unsigned T_SHDN    = 150
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [VW-1:0] supply_code_i,
  input  logic [TW-1:0] temp_code_i,
  input  logic          ext_en_i,
  output logic          supply_ok_o,
  output logic          therm_warn_o,
  output logic          shdn_o,
  output logic          en_pull_o,
  output logic          run_permit_o
);
  localparam int unsigned CapW = VW + TW + 1;
  localparam logic [TW-1:0] ShdnC = T_SHDN[TW-1:0];

  logic [CapW-1:0] cap_q;
  logic [VW-1:0]   v_q;
  logic [TW-1:0]   t_q;
  logic            en_q;
  guard_flags_t    flags;

  in_capture #(.W(CapW)) u_cap (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({supply_code_i, temp_code_i, ext_en_i}),
    .q_o   (cap_q)
  );
  assign {v_q, t_q, en_q} = cap_q;

  hyst_cmp #(.W(VW), .HI(V_START), .LO(V_STOP)) u_uvlo (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .val_i (v_q),
    .flag_o(flags.supply_ok)
  );

  hyst_cmp #(.W(TW), .HI(T_WARN_HI), .LO(T_WARN_LO)) u_warn (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .val_i (t_q),
    .flag_o(flags.warn)
  );

  trip_latch u_shdn (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .arm_i  (flags.supply_ok),
    .trip_i (t_q > ShdnC),
    .latch_o(flags.shdn)
  );

  assign supply_ok_o  = flags.supply_ok;
  assign therm_warn_o = flags.warn;
  assign shdn_o       = flags.shdn;
  assign en_pull_o    = flags.shdn;
  assign run_permit_o = flags.supply_ok & ~flags.shdn & en_q;

  p_trip_blocks_run_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(shdn_o) |-> (!run_permit_o && en_pull_o));
  p_no_run_without_supply_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(supply_ok_o) |-> !run_permit_o);
endmodule

// File: tb/tb_pwr_therm_guard.sv
`timescale 1ns/1ps
module tb_pwr_therm_guard;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] v = '0;
  logic [7:0] t = '0;
  logic       e = 1'b0;
  logic       ok, warn, shdn, pull, permit;
  int         n_chk = 0, n_bad = 0;
  bit         done = 0;

  always #4 clk = ~clk;  // 125 MHz

  pwr_therm_guard dut (
    .clk_i(clk), .rst_ni(rst_n), .supply_code_i(v), .temp_code_i(t),
    .ext_en_i(e), .supply_ok_o(ok), .therm_warn_o(warn), .shdn_o(shdn),
    .en_pull_o(pull), .run_permit_o(permit)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  // drive at a falling edge, sample after two rising edges
  task automatic apply(input int vv, input int tt, input logic ee);
    v = vv[9:0]; t = tt[7:0]; e = ee;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk("R1 supply_ok", ok, 0);   chk("R1 warn", warn, 0);
    chk("R1 shdn", shdn, 0);      chk("R1 en_pull", pull, 0);
    chk("R1 permit", permit, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_supply;
    apply(430, 25, 1); chk("R2 equal start", ok, 0);
    apply(431, 25, 1); chk("R2 above start", ok, 1);
    chk("R10 permit on", permit, 1);
    apply(381, 25, 1); chk("R3 hold in band", ok, 1);
    apply(380, 25, 1); chk("R3 clear at stop", ok, 0);
    chk("R10 permit off no supply", permit, 0);
    apply(420, 25, 1); chk("R3 stay low in band", ok, 0);
    apply(500, 25, 1); chk("R2 restart", ok, 1);
  endtask

  task automatic t_warn;
    apply(500, 115, 1); chk("R4 equal hi", warn, 0);
    apply(500, 116, 1); chk("R4 above hi", warn, 1);
    chk("R6 warn no effect", permit, 1);
    apply(500, 101, 1); chk("R5 hold in band", warn, 1);
    apply(500, 100, 1); chk("R5 clear at lo", warn, 0);
  endtask

  task automatic t_shutdown;
    apply(500, 150, 1); chk("R7 equal limit", shdn, 0);
    apply(500, 151, 1); chk("R7 trip", shdn, 1);
    chk("R7 en_pull", pull, 1);
    chk("R10 permit blocked", permit, 0);
    apply(500, 25, 1);  chk("R8 cool keeps latch", shdn, 1);
    apply(381, 25, 1);  chk("R8 dip in band keeps latch", shdn, 1);
    apply(380, 25, 1);  chk("R9 supply drops", ok, 0);
    chk("R9 latch one edge later", shdn, 1);
    @(negedge clk);     chk("R9 latch released", shdn, 0);
    chk("R7 en_pull released", pull, 0);
    apply(300, 200, 1); @(negedge clk);
    chk("R9 no trip in uv", shdn, 0);
    apply(500, 25, 1);  chk("R9 recovered permit", permit, 1);
  endtask

  task automatic t_permit;
    v = 10'd500; t = 8'd25; e = 1'b0;
    @(negedge clk); chk("R10 ext low", permit, 0);
    e = 1'b1;
    @(negedge clk); chk("R10 ext high", permit, 1);
    chk("R10 ok still", ok, 1);
  endtask

  initial begin
    t_reset();
    t_supply();
    t_warn();
    t_shutdown();
    t_permit();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule